// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that counts down in its own slow clock domain (`wd_clk`). Software controls it only through a small register interface in the bus clock domain (`clk`). A 32-bit key register takes command words. One word starts the count, one reloads the counter, and one opens the two configuration registers for writing. The configuration registers are a 3-bit divider code and a 12-bit reload value. Once the watchdog runs, nothing can stop it. If software fails to reload it in time, it emits a one-cycle reset request in the watchdog clock domain.

Every command and configuration value crosses into the watchdog domain by a toggle handshake. Each configuration register has a busy status bit. The bit stays set from an accepted write until the watchdog domain has taken the new value and the acknowledge has come back.

A strap input makes the watchdog run straight out of reset. A debug-halt input pauses the count when the freeze enable is set.

Top module: `keyed_watchdog`

## Requirements
- R1: Writing 0x0000AAAA to the key register (address 0) loads the counter from the reload value and restarts the divider. Repeated at intervals shorter than the timeout, this prevents any reset request.
- R2: Writes to the divider register (address 1, bits [2:0]) and to the reload register (address 2, bits [11:0]) are ignored unless the configuration is unlocked. Both registers read back their current value at their own address, and the reset values are 0 and 0xFFF.
- R3: Writing 0x00005555 to the key register unlocks the configuration. Writing any other key word locks it again.
- R4: Writing 0x0000CCCC to the key register starts the count from 0xFFF. With the default divider, the first reset request comes 4096 x 4 watchdog cycles later.
- R5: With `hw_start` low, the watchdog stays idle after reset and makes no request until it is started. With `hw_start` high, it runs from reset without any key write.
- R6: Once running, the watchdog keeps running whatever key words are written.
- R7: The status register (address 3) has bit 0 as divider busy and bit 1 as reload busy. A busy bit reads 1 on the bus cycle after an accepted write to its register. It clears within 8 watchdog cycles plus 4 bus cycles, and it reads 0 after reset.
- R8: A write to a configuration register while its busy bit is set is ignored.
- R9: With reload value R and divide ratio D, a request fires (R+1) x D watchdog cycles after a reload. The request lasts exactly one watchdog cycle. The counter then reloads itself and the request repeats with the same period.
- R10: The divide ratio is 4 shifted left by the divider code for codes 0 to 6, and code 7 also gives 256.
- R11: While `freeze_en` and `dbg_halt` are both high, the count pauses and no request fires. With `freeze_en` low, `dbg_halt` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| wd_clk | input | 1 | Watchdog counting clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| hw_start | input | 1 | Strap: run from reset when high |
| wr_en | input | 1 | Register write strobe (bus domain) |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| dbg_halt | input | 1 | Core halted in debug |
| freeze_en | input | 1 | Lets `dbg_halt` pause the count |
| wdt_reset | output | 1 | Reset request, one `wd_clk` cycle wide |

## Verification
The properties assume three things about the inputs:
- `rst_n` is applied to both domains together.
- `hw_start` changes only while reset is asserted.
- Successive reload keys are spaced several watchdog cycles apart, so that two toggles of the same command never merge in the synchroniser.

The stimulus keeps to these rules:
- It changes the strap only inside a reset pulse.
- It spaces reload writes about ten watchdog cycles apart.
- It drives all bus inputs at the falling bus edge.
- It runs the watchdog clock at a fixed, non-aligned phase, so that the handoff latency stays inside the windows the reference model allows.

// File: rtl/kwdg_pkg.sv
`timescale 1ns/1ps
package kwdg_pkg;
  localparam int PRE_W  = 3;
  localparam int DATA_W = 32;
  localparam int DIV_W  = 9;

  localparam logic [DATA_W-1:0] KEY_UNLOCK  = 32'h0000_5555;
  localparam logic [DATA_W-1:0] KEY_REFRESH = 32'h0000_AAAA;
  localparam logic [DATA_W-1:0] KEY_START   = 32'h0000_CCCC;

  typedef enum logic [1:0] {
    A_KEY  = 2'd0,
    A_PRE  = 2'd1,
    A_RLD  = 2'd2,
    A_STAT = 2'd3
  } reg_addr_e;

  // divide ratio selected by a divider code; top code saturates at 256
  function automatic logic [DIV_W-1:0] div_of(input logic [PRE_W-1:0] code);
    if (code == '1) return DIV_W'(256);
    return DIV_W'(4) << code;
  endfunction
endpackage

// File: rtl/kwdg_sync.sv
`timescale 1ns/1ps
module kwdg_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/kwdg_regs.sv
`timescale 1ns/1ps
module kwdg_regs
  import kwdg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pr_ack,
  input  logic              rl_ack,
  output logic [PRE_W-1:0]  pr_val,
  output logic [CNT_W-1:0]  rl_val,
  output logic              pr_req,
  output logic              rl_req,
  output logic              start_req,
  output logic              kick_req,
  output logic              unlocked,
  output logic              pr_busy,
  output logic              rl_busy
);
  // a handoff is in flight while request and returned acknowledge differ
  assign pr_busy = pr_req ^ pr_ack;
  assign rl_busy = rl_req ^ rl_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked  <= 1'b0;
      pr_val    <= '0;
      rl_val    <= '1;
      pr_req    <= 1'b0;
      rl_req    <= 1'b0;
      start_req <= 1'b0;
      kick_req  <= 1'b0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        A_KEY: begin
          unlocked <= (wr_data == KEY_UNLOCK);
          if (wr_data == KEY_REFRESH) kick_req  <= ~kick_req;
          if (wr_data == KEY_START)   start_req <= ~start_req;
        end
        A_PRE: if (unlocked && !pr_busy) begin
          pr_val <= wr_data[PRE_W-1:0];
          pr_req <= ~pr_req;
        end
        A_RLD: if (unlocked && !rl_busy) begin
          rl_val <= wr_data[CNT_W-1:0];
          rl_req <= ~rl_req;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_addr_e'(rd_addr))
      A_PRE:   rd_data[PRE_W-1:0] = pr_val;
      A_RLD:   rd_data[CNT_W-1:0] = rl_val;
      A_STAT:  rd_data[1:0]       = {rl_busy, pr_busy};
      default: rd_data            = '0;
    endcase
  end
endmodule

// File: rtl/kwdg_core.sv
`timescale 1ns/1ps
module kwdg_core
  import kwdg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             wd_clk,
  input  logic             rst_n,
  input  logic             hw_start,
  input  logic             start_t,
  input  logic             kick_t,
  input  logic             pr_t,
  input  logic             rl_t,
  input  logic             freeze,
  input  logic [PRE_W-1:0] pr_val,
  input  logic [CNT_W-1:0] rl_val,
  output logic             pr_ack,
  output logic             rl_ack,
  output logic             running,
  output logic             rst_req
);
  localparam int PCW = DIV_W - 1;

  logic             start_seen, kick_seen, run_q;
  logic [PRE_W-1:0] code_q;
  logic [CNT_W-1:0] rld_q, cnt_q;
  logic [PCW-1:0]   pcnt_q, last;
  logic [DIV_W-1:0] ratio;
  logic             start_ev, kick_ev, pr_ev, rl_ev;

  assign ratio    = div_of(code_q);
  assign last     = PCW'(ratio - DIV_W'(1));
  assign start_ev = start_t ^ start_seen;
  assign kick_ev  = kick_t ^ kick_seen;
  assign pr_ev    = pr_t ^ pr_ack;
  assign rl_ev    = rl_t ^ rl_ack;
  assign running  = run_q | hw_start;

  always_ff @(posedge wd_clk or negedge rst_n) begin
    if (!rst_n) begin
      start_seen <= 1'b0;
      kick_seen  <= 1'b0;
      pr_ack     <= 1'b0;
      rl_ack     <= 1'b0;
      run_q      <= 1'b0;
      code_q     <= '0;
      rld_q      <= '1;
      cnt_q      <= '1;
      pcnt_q     <= '0;
      rst_req    <= 1'b0;
    end else begin
      start_seen <= start_t;
      kick_seen  <= kick_t;
      pr_ack     <= pr_t;
      rl_ack     <= rl_t;
      if (pr_ev)    code_q <= pr_val;
      if (rl_ev)    rld_q  <= rl_val;
      if (start_ev) run_q  <= 1'b1;
      rst_req <= 1'b0;
      if (kick_ev) begin
        cnt_q  <= rld_q;
        pcnt_q <= '0;
      end else if (running && !freeze) begin
        if (pcnt_q >= last) begin
          pcnt_q <= '0;
          if (cnt_q == '0) begin
            rst_req <= 1'b1;
            cnt_q   <= rld_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end else begin
          pcnt_q <= pcnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
module keyed_watchdog
  import kwdg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic        clk,
  input  logic        wd_clk,
  input  logic        rst_n,
  input  logic        hw_start,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        dbg_halt,
  input  logic        freeze_en,
  output logic        wdt_reset
);
  logic [PRE_W-1:0] pr_val;
  logic [CNT_W-1:0] rl_val;
  logic pr_req, rl_req, start_req, kick_req, unlocked, pr_busy, rl_busy;
  logic pr_ack_wd, rl_ack_wd, running;
  logic [3:0] req_wd;
  logic [1:0] ack_bus;
  logic [0:0] freeze_wd;

  kwdg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pr_ack(ack_bus[0]), .rl_ack(ack_bus[1]), .pr_val(pr_val),
    .rl_val(rl_val), .pr_req(pr_req), .rl_req(rl_req),
    .start_req(start_req), .kick_req(kick_req), .unlocked(unlocked),
    .pr_busy(pr_busy), .rl_busy(rl_busy)
  );

  kwdg_sync #(.W(4)) u_to_wd (
    .clk(wd_clk), .rst_n(rst_n),
    .d({rl_req, pr_req, kick_req, start_req}), .q(req_wd)
  );

  kwdg_sync #(.W(1)) u_freeze (
    .clk(wd_clk), .rst_n(rst_n), .d(freeze_en & dbg_halt), .q(freeze_wd)
  );

  kwdg_sync #(.W(2)) u_to_bus (
    .clk(clk), .rst_n(rst_n), .d({rl_ack_wd, pr_ack_wd}), .q(ack_bus)
  );

  kwdg_core #(.CNT_W(CNT_W)) u_core (
    .wd_clk(wd_clk), .rst_n(rst_n), .hw_start(hw_start),
    .start_t(req_wd[0]), .kick_t(req_wd[1]), .pr_t(req_wd[2]),
    .rl_t(req_wd[3]), .freeze(freeze_wd[0]), .pr_val(pr_val),
    .rl_val(rl_val), .pr_ack(pr_ack_wd), .rl_ack(rl_ack_wd),
    .running(running), .rst_req(wdt_reset)
  );
endmodule

// File: rtl/kwdg_chk.sv
`timescale 1ns/1ps
module kwdg_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             wd_clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic             unlocked,
  input logic [2:0]       pr_val,
  input logic [CNT_W-1:0] rl_val,
  input logic             rl_busy,
  input logic             running,
  input logic             wdt_reset
);
  assert_locked_pre_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1 && !unlocked) |=> $stable(pr_val));

  assert_busy_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2 && unlocked && !rl_busy) |=> rl_busy);

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2 && rl_busy) |=> $stable(rl_val));

  assert_no_stop_R6: assert property (@(posedge wd_clk) disable iff (!rst_n)
    running |=> running);

  assert_one_cycle_R9: assert property (@(posedge wd_clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset);

  assert_req_when_run_R4: assert property (@(posedge wd_clk) disable iff (!rst_n)
    wdt_reset |-> running);
endmodule

bind keyed_watchdog kwdg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .wd_clk(wd_clk), .rst_n(rst_n), .wr_en(wr_en),
  .wr_addr(wr_addr), .unlocked(unlocked), .pr_val(pr_val),
  .rl_val(rl_val), .rl_busy(rl_busy), .running(running),
  .wdt_reset(wdt_reset)
);

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
  logic clk = 0, wd_clk = 0, rst_n = 0, hw_start = 0;
  logic wr_en = 0, dbg_halt = 0, freeze_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, s;
  wire  [31:0] rd_data;
  wire         wdt_reset;

  localparam logic [31:0] K_UNL = 32'h0000_5555;
  localparam logic [31:0] K_REF = 32'h0000_AAAA;
  localparam logic [31:0] K_GO  = 32'h0000_CCCC;

  keyed_watchdog uut (
    .clk(clk), .wd_clk(wd_clk), .rst_n(rst_n), .hw_start(hw_start),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .dbg_halt(dbg_halt),
    .freeze_en(freeze_en), .wdt_reset(wdt_reset)
  );

  always #2.5 clk = ~clk;
  initial begin
    #1.3;
    forever #5 wd_clk = ~wd_clk;
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // reference model: watchdog-cycle clock, pulse log, expected period
  int  wd_cyc = 0, last_pulse = 0, mdl_period = 0;
  int  pulse_q[$];
  bit  prev_req = 0, mdl_armed = 0;

  always @(negedge wd_clk) begin
    if (!rst_n) begin
      wd_cyc   = 0;
      prev_req = 0;
    end else begin
      wd_cyc++;
      if (wdt_reset) begin
        pulse_q.push_back(wd_cyc);
        check(!prev_req, "R9 request width one cycle", 2, 1);
        if (mdl_armed)
          check(wd_cyc - last_pulse == mdl_period, "R9 period",
                wd_cyc - last_pulse, mdl_period);
        last_pulse = wd_cyc;
      end else if (mdl_armed && wd_cyc - last_pulse > mdl_period) begin
        check(0, "R9 missing request", wd_cyc - last_pulse, mdl_period);
        mdl_armed = 0;
      end
      prev_req = wdt_reset;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] st;
    int n = 0;
    do begin
      rd(2'd3, st);
      n++;
    end while (st[1:0] != 0 && n < 40);
    check(st[1:0] == 0, tag, st[1:0], 0);
  endtask

  task automatic expect_pulse(input int lo, input int hi, input string tag);
    int t0 = wd_cyc;
    pulse_q.delete();
    while (pulse_q.size() == 0 && wd_cyc - t0 <= hi + 4) @(negedge clk);
    if (pulse_q.size() == 0) check(0, tag, -1, lo);
    else check(pulse_q[0] - t0 >= lo && pulse_q[0] - t0 <= hi, tag, pulse_q[0] - t0, lo);
  endtask

  task automatic arm(input int p);
    mdl_period = p;
    mdl_armed  = 1;
  endtask

  initial begin
    #(190000 * 5);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    #23 rst_n = 1;
    @(negedge clk);
    check(wdt_reset == 0, "R5 no request after reset", wdt_reset, 0);
    rd(2'd3, s); check(s == 0, "R7 status clear after reset", s, 0);
    rd(2'd2, s); check(s == 32'hFFF, "R2 reload reset value", s, 32'hFFF);
    rd(2'd1, s); check(s == 0, "R2 divider reset value", s, 0);

    wr(2'd2, 32'd3); rd(2'd2, s); check(s == 32'hFFF, "R2 locked reload write", s, 32'hFFF);
    wr(2'd1, 32'd5); rd(2'd1, s); check(s == 0, "R2 locked divider write", s, 0);

    pulse_q.delete();
    repeat (600) @(negedge wd_clk);
    check(pulse_q.size() == 0, "R5 idle until start key", pulse_q.size(), 0);

    wr(2'd0, K_GO);
    expect_pulse(16384, 16390, "R4 first timeout from 0xFFF");

    // accepted write, busy, write while busy
    wr(2'd0, K_UNL);
    wr(2'd2, 32'd3);
    rd(2'd3, s); check(s[1] == 1, "R7 reload busy set", s[1], 1);
    wr(2'd2, 32'd9);
    wait_idle("R7 busy clears");
    rd(2'd2, s); check(s == 3, "R8 write while busy ignored", s, 3);

    wr(2'd0, 32'h0000_1234);
    wr(2'd2, 32'd5);
    rd(2'd2, s); check(s == 3, "R3 other key relocks", s, 3);

    wr(2'd0, K_REF);
    expect_pulse(16, 22, "R9 timeout after refresh");
    arm(16);
    repeat (70) @(negedge wd_clk);
    check(pulse_q.size() >= 5, "R9 request repeats", pulse_q.size(), 5);

    mdl_armed = 0;
    pulse_q.delete();
    repeat (20) begin
      wr(2'd0, K_REF);
      repeat (10) @(negedge wd_clk);
    end
    check(pulse_q.size() == 0, "R1 refresh prevents request", pulse_q.size(), 0);

    // divider code 7 and code 1
    wr(2'd0, K_UNL); wr(2'd1, 32'd7); wait_idle("R7 divider busy clears");
    wr(2'd2, 32'd0); wait_idle("R7 reload busy clears");
    rd(2'd1, s); check(s == 7, "R2 unlocked divider write", s, 7);
    wr(2'd0, K_REF);
    expect_pulse(256, 262, "R10 code 7 divides by 256");
    arm(256);
    repeat (520) @(negedge wd_clk);
    check(pulse_q.size() >= 3, "R10 code 7 repeats", pulse_q.size(), 3);

    mdl_armed = 0;
    wr(2'd0, K_UNL); wr(2'd1, 32'd1); wait_idle("R7 divider busy clears");
    wr(2'd0, K_REF);
    expect_pulse(8, 14, "R10 code 1 divides by 8");
    arm(8);
    repeat (40) @(negedge wd_clk);
    check(pulse_q.size() >= 5, "R10 code 1 repeats", pulse_q.size(), 5);

    // debug freeze
    mdl_armed = 0;
    wr(2'd0, K_UNL); wr(2'd1, 32'd0); wr(2'd2, 32'd3); wait_idle("R7 busy clears");
    wr(2'd0, K_REF);
    expect_pulse(16, 22, "R9 timeout div 4 reload 3");
    arm(16);
    mdl_armed = 0;
    freeze_en = 1; dbg_halt = 1;
    repeat (4) @(negedge wd_clk);
    pulse_q.delete();
    repeat (200) @(negedge wd_clk);
    check(pulse_q.size() == 0, "R11 frozen count", pulse_q.size(), 0);
    dbg_halt = 0;
    expect_pulse(1, 22, "R11 count resumes");
    freeze_en = 0; dbg_halt = 1;
    expect_pulse(1, 20, "R11 halt ignored without enable");
    arm(16);
    repeat (70) @(negedge wd_clk);
    check(pulse_q.size() >= 5, "R11 running while halted", pulse_q.size(), 5);

    // no key stops it
    wr(2'd0, 32'h0); wr(2'd0, 32'hFFFF_FFFF); wr(2'd0, K_UNL); wr(2'd0, K_GO);
    pulse_q.delete();
    repeat (40) @(negedge wd_clk);
    check(pulse_q.size() >= 2, "R6 keys cannot stop it", pulse_q.size(), 2);
    dbg_halt = 0;

    // hardware start
    mdl_armed = 0;
    @(negedge clk);
    #1 rst_n = 0;
    hw_start = 1;
    #21 rst_n = 1;
    expect_pulse(16380, 16390, "R5 hardware start runs from reset");

    finish_run();
  end
endmodule